// File: doc/BRIEF.md
# Interrupt Notification Write Generator

This block turns interrupt source activity into memory writes. Each source reports changes of its level through a single event port. The block records the current level of every source in a level register. Bit numbering is most-significant-bit first, so source s occupies bit 63-s. When an accepted event asserts a source and the notification address is marked valid, the block queues one 64-bit write. That write carries a logical interrupt number, equal to the upper half of a programmable table-offset register plus the source number, and the data is laid out big-endian.

Software reaches the block through a simple synchronous configuration port that uses byte offsets. It sets the notification address and the table offset there. A control register holds a method bit, which makes the block refuse all events, and a reset bit, which sends a one-cycle reset pulse to the attached source logic. Notification requests wait in a small in-order queue until the downstream write port accepts them with a valid/ready handshake. A request that finds the queue full is dropped and sets a sticky overflow flag.

Top module: `intn_notify_gen`

## Requirements
- R1: After reset every register reads zero, `nw_valid`, `nw_ovf`, `src_rst` and both error outputs are low.
- R2: An accepted event on source s sets (level 1) or clears (level 0) bit 63-s of the level register (offset 0x78), visible on the read port after the next clock edge; no other level bit changes.
- R3: While bit 63 (method) of the control register (offset 0x58) is set, every event is refused: `evt_method_err` is high for the one cycle after the event, the level register is unchanged and no write is queued.
- R4: With the method bit clear, an event whose index is NUM_SRC or above is ignored: `evt_range_err` is high for the one cycle after it, the level register is unchanged and no write is queued.
- R5: A configuration write to the control register with bit 62 set raises `src_rst` for exactly the one following cycle, and the whole written value is stored and read back.
- R6: An accepted asserting event, while bit 0 of the notification address register (offset 0x68) is set, queues a write whose address is that register with bit 0 cleared. Its data is the 64-bit value ((table offset register at 0x70 >> 32) + s) mod 2^32, zero-extended and byte-swapped, so that lane k (`nw_data[8k+7:8k]`) holds byte k of the big-endian value. Register values are those in force in the event's cycle.
- R7: When bit 0 of the notification address register is clear, accepted events update the level register but queue no write.
- R8: Queued writes leave in arrival order. A request with `nw_valid` high keeps `nw_valid`, `nw_addr` and `nw_data` stable until `nw_ready` is high. Up to DEPTH requests are held, and a request is taken even when the queue is full if a write leaves in the same cycle.
- R9: A request that arrives while DEPTH requests are held and none leaves is dropped, and `nw_ovf` goes high and stays high until reset.
- R10: Writes to the level register are ignored. The event-buffer base register (offset 0x60) reads back what was written, and a read of any other offset returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (write and read) |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Read data for `cfg_addr`, combinational |
| evt_vld | input | 1 | Source level change present |
| evt_idx | input | IDX_W | Source number |
| evt_lvl | input | 1 | New level of the source |
| evt_method_err | output | 1 | Event refused by the method bit (one cycle) |
| evt_range_err | output | 1 | Event index out of range (one cycle) |
| src_rst | output | 1 | One-cycle reset pulse to the source logic |
| nw_valid | output | 1 | Notification write request pending |
| nw_ready | input | 1 | Downstream accepts the write |
| nw_addr | output | 64 | Notification write address |
| nw_data | output | 64 | Big-endian logical interrupt number |
| nw_ovf | output | 1 | Sticky queue overflow |

## Verification
The bench uses the defaults NUM_SRC = 14, IDX_W = 5 and DEPTH = 4. A five-bit index can then name sources 14 to 31, which makes the range refusal reachable with ordinary stimulus. A queue of only four entries fills after a few cycles with `nw_ready` held low, so overflow, the full-queue push that coincides with a pop, and in-order drain all appear in both the directed and the random phases. A table offset with all-ones upper half brings the 32-bit wrap of the interrupt number into a directed check.

// File: rtl/intn_pkg.sv
package intn_pkg;

   localparam int unsigned CFG_AW   = 8;
   localparam int unsigned WORD_W   = 64;
   localparam int unsigned LISN_W   = 32;

   // byte offsets of the configuration registers
   localparam logic [CFG_AW-1:0] OFS_CTRL  = 8'h58;
   localparam logic [CFG_AW-1:0] OFS_EBASE = 8'h60;
   localparam logic [CFG_AW-1:0] OFS_NADDR = 8'h68;
   localparam logic [CFG_AW-1:0] OFS_TOFF  = 8'h70;
   localparam logic [CFG_AW-1:0] OFS_LEVEL = 8'h78;

   // MSB-first bit 0 and bit 1 of the control register
   localparam int unsigned CTRL_METHOD_BIT = 63;
   localparam int unsigned CTRL_RESET_BIT  = 62;

   typedef struct packed {
      logic [WORD_W-1:0] addr;
      logic [LISN_W-1:0] lisn;
   } nreq_t;

   function automatic logic [WORD_W-1:0] to_big_endian(input logic [WORD_W-1:0] v);
      logic [WORD_W-1:0] r;
      for (int k = 0; k < WORD_W/8; k++) begin
         r[8*k +: 8] = v[WORD_W-8-8*k +: 8];
      end
      return r;
   endfunction

endpackage

// File: rtl/intn_regs.sv
module intn_regs
   import intn_pkg::*;
#(
   parameter int unsigned NUM_SRC = 14,
   parameter int unsigned IDX_W   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CFG_AW-1:0]   addr,
   input  logic [WORD_W-1:0]   wdata,
   output logic [WORD_W-1:0]   rdata,
   input  logic                lvl_we,
   input  logic [IDX_W-1:0]    lvl_idx,
   input  logic                lvl_val,
   output logic                method_o,
   output logic [WORD_W-1:0]   naddr_o,
   output logic [LISN_W-1:0]   toff_hi_o,
   output logic                src_rst_o
);

   generate
      if (NUM_SRC < 1 || NUM_SRC > WORD_W || NUM_SRC > (1 << IDX_W)) begin : g_bad_num
         $error("intn_regs: NUM_SRC must be 1..64 and fit in IDX_W bits");
      end
   endgenerate

   logic [WORD_W-1:0] ctrl_q, ebase_q, naddr_q, toff_q;
   logic [WORD_W-1:0] level_q;
   logic              rst_pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         ebase_q     <= '0;
         naddr_q     <= '0;
         toff_q      <= '0;
         rst_pulse_q <= 1'b0;
      end else begin
         rst_pulse_q <= wr_en && (addr == OFS_CTRL) && wdata[CTRL_RESET_BIT];
         if (wr_en) begin
            unique case (addr)
               OFS_CTRL:  ctrl_q  <= wdata;
               OFS_EBASE: ebase_q <= wdata;
               OFS_NADDR: naddr_q <= wdata;
               OFS_TOFF:  toff_q  <= wdata;
               default: ;
            endcase
         end
      end
   end

   // level register: source s lives at bit 63-s; bits without a source read zero
   generate
      for (genvar g = 0; g < WORD_W; g++) begin : g_lvl
         localparam int unsigned SRC = WORD_W - 1 - g;
         if (SRC < NUM_SRC) begin : g_bit
            logic b_q;
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  b_q <= 1'b0;
               end else if (lvl_we && (lvl_idx == IDX_W'(SRC))) begin
                  b_q <= lvl_val;
               end
            end
            assign level_q[g] = b_q;
         end else begin : g_none
            assign level_q[g] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      unique case (addr)
         OFS_CTRL:  rdata = ctrl_q;
         OFS_EBASE: rdata = ebase_q;
         OFS_NADDR: rdata = naddr_q;
         OFS_TOFF:  rdata = toff_q;
         OFS_LEVEL: rdata = level_q;
         default:   rdata = '1;
      endcase
   end

   assign method_o  = ctrl_q[CTRL_METHOD_BIT];
   assign naddr_o   = naddr_q;
   assign toff_hi_o = toff_q[WORD_W-1 -: LISN_W];
   assign src_rst_o = rst_pulse_q;

   // R5: reset request on the control register yields a pulse next cycle
   p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == OFS_CTRL && wdata[CTRL_RESET_BIT]) |=> src_rst_o);
   // R5: a pulse only follows such a write
   p_rst_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && addr == OFS_CTRL && wdata[CTRL_RESET_BIT])) |=> !src_rst_o);
   // R3/R4/R10: without a level update request the level register holds
   p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_we |=> $stable(level_q));

endmodule

// File: rtl/intn_evt.sv
module intn_evt
   import intn_pkg::*;
#(
   parameter int unsigned NUM_SRC = 14,
   parameter int unsigned IDX_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_vld,
   input  logic [IDX_W-1:0]   evt_idx,
   input  logic               evt_lvl,
   input  logic               method,
   input  logic [WORD_W-1:0]  naddr,
   input  logic [LISN_W-1:0]  toff_hi,
   output logic               lvl_we,
   output logic [IDX_W-1:0]   lvl_idx,
   output logic               lvl_val,
   output logic               push,
   output nreq_t              push_req,
   output logic               method_err_o,
   output logic               range_err_o
);

   logic in_range, refuse, accept;
   logic method_err_q, range_err_q;

   assign in_range = (32'(evt_idx) < NUM_SRC);
   assign refuse   = evt_vld && method;
   assign accept   = evt_vld && !method && in_range;

   assign lvl_we  = accept;
   assign lvl_idx = evt_idx;
   assign lvl_val = evt_lvl;

   assign push          = accept && evt_lvl && naddr[0];
   assign push_req.addr = {naddr[WORD_W-1:1], 1'b0};
   assign push_req.lisn = toff_hi + LISN_W'(evt_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         method_err_q <= 1'b0;
         range_err_q  <= 1'b0;
      end else begin
         method_err_q <= refuse;
         range_err_q  <= evt_vld && !method && !in_range;
      end
   end

   assign method_err_o = method_err_q;
   assign range_err_o  = range_err_q;

   // R3: a refused event never reaches the level register or the queue
   p_method_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vld && method) |-> (!lvl_we && !push));
   // R3: refusal is reported in the next cycle
   p_method_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vld && method) |=> method_err_o);
   // R4: an out-of-range index is never written
   p_range_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vld && 32'(evt_idx) >= NUM_SRC) |-> !lvl_we);
   // R7: no request without the valid flag of the address register
   p_naddr_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> naddr[0]);

endmodule

// File: rtl/intn_fifo.sv
module intn_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 96
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic          not_empty,
   output logic          ovf_o
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("intn_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             do_pop, do_push;

   assign not_empty = (cnt_q != '0);
   assign do_pop    = pop && not_empty;
   assign do_push   = push && ((cnt_q < CNT_W'(DEPTH)) || do_pop);
   assign head      = mem[rp_q];

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wp_q] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
         if (push && !do_push) ovf_q <= 1'b1;
      end
   end

   assign ovf_o = ovf_q;

   // R8: a waiting head stays put until it is taken
   p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (not_empty && !pop) |=> (not_empty && $stable(head)));
   // R8: occupancy never exceeds the depth
   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
   // R9: overflow flag is sticky
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);

endmodule

// File: rtl/intn_notify_gen.sv
module intn_notify_gen
   import intn_pkg::*;
#(
   parameter int unsigned NUM_SRC = 14,
   parameter int unsigned IDX_W   = 5,
   parameter int unsigned DEPTH   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [7:0]         cfg_addr,
   input  logic [63:0]        cfg_wdata,
   output logic [63:0]        cfg_rdata,
   input  logic               evt_vld,
   input  logic [IDX_W-1:0]   evt_idx,
   input  logic               evt_lvl,
   output logic               evt_method_err,
   output logic               evt_range_err,
   output logic               src_rst,
   output logic               nw_valid,
   input  logic               nw_ready,
   output logic [63:0]        nw_addr,
   output logic [63:0]        nw_data,
   output logic               nw_ovf
);

   localparam int unsigned REQ_W = $bits(nreq_t);

   logic              lvl_we, lvl_val, method, push;
   logic [IDX_W-1:0]  lvl_idx;
   logic [WORD_W-1:0] naddr;
   logic [LISN_W-1:0] toff_hi;
   nreq_t             push_req, head_req;
   logic [REQ_W-1:0]  head_bits;

   intn_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .rdata     (cfg_rdata),
      .lvl_we    (lvl_we),
      .lvl_idx   (lvl_idx),
      .lvl_val   (lvl_val),
      .method_o  (method),
      .naddr_o   (naddr),
      .toff_hi_o (toff_hi),
      .src_rst_o (src_rst)
   );

   intn_evt #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_evt (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_vld      (evt_vld),
      .evt_idx      (evt_idx),
      .evt_lvl      (evt_lvl),
      .method       (method),
      .naddr        (naddr),
      .toff_hi      (toff_hi),
      .lvl_we       (lvl_we),
      .lvl_idx      (lvl_idx),
      .lvl_val      (lvl_val),
      .push         (push),
      .push_req     (push_req),
      .method_err_o (evt_method_err),
      .range_err_o  (evt_range_err)
   );

   intn_fifo #(.DEPTH(DEPTH), .W(REQ_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .din       (push_req),
      .pop       (nw_ready),
      .head      (head_bits),
      .not_empty (nw_valid),
      .ovf_o     (nw_ovf)
   );

   assign head_req = nreq_t'(head_bits);
   assign nw_addr  = head_req.addr;
   assign nw_data  = to_big_endian({{(WORD_W-LISN_W){1'b0}}, head_req.lisn});

   // R6: notification addresses are always word aligned at bit 0
   p_addr_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
      nw_valid |-> !nw_addr[0]);
   // R6: the upper half of the payload bytes (lanes 0..3) are zero
   p_data_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      nw_valid |-> (nw_data[31:0] == 32'h0));

endmodule

// File: tb/intn_notify_gen_bench.sv
module intn_notify_gen_bench;
   localparam int unsigned NUM_SRC = 14;
   localparam int unsigned IDX_W   = 5;
   localparam int unsigned DEPTH   = 4;
   localparam logic [7:0] A_CTRL = 8'h58, A_EBASE = 8'h60, A_NADDR = 8'h68,
                          A_TOFF = 8'h70, A_LEVEL = 8'h78;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [7:0] cfg_addr = 8'h0;
   logic [63:0] cfg_wdata = '0;
   logic [63:0] cfg_rdata;
   logic evt_vld = 1'b0;
   logic [IDX_W-1:0] evt_idx = '0;
   logic evt_lvl = 1'b0;
   logic evt_method_err, evt_range_err, src_rst, nw_valid, nw_ovf;
   logic nw_ready = 1'b0;
   logic [63:0] nw_addr, nw_data;

   always #5 clk = ~clk;

   intn_notify_gen #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .DEPTH(DEPTH)) u_intn_notify_gen (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_vld(evt_vld),
      .evt_idx(evt_idx), .evt_lvl(evt_lvl), .evt_method_err(evt_method_err),
      .evt_range_err(evt_range_err), .src_rst(src_rst), .nw_valid(nw_valid),
      .nw_ready(nw_ready), .nw_addr(nw_addr), .nw_data(nw_data), .nw_ovf(nw_ovf));

   int checks = 0;
   int failures = 0;

   // reference model
   logic [63:0] m_level = '0, m_ctrl = '0, m_ebase = '0, m_naddr = '0, m_toff = '0;
   logic [63:0] q_addr [8];
   logic [63:0] q_data [8];
   int q_head = 0, q_cnt = 0;
   logic m_ovf = 1'b0, x_merr = 1'b0, x_rerr = 1'b0, x_rst = 1'b0;

   function automatic logic [63:0] swap_bytes(input logic [63:0] v);
      logic [63:0] r;
      for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
      return r;
   endfunction

   function automatic logic [63:0] exp_payload(input logic [63:0] toff, input int idx);
      logic [31:0] n;
      n = toff[63:32] + 32'(idx);
      return swap_bytes({32'h0, n});
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // compare outputs against the model, drive one cycle of stimulus, advance
   task automatic step(input logic ev, input int idx, input logic lvl, input logic rdy,
                       input logic wr, input logic [7:0] wa, input logic [63:0] wd);
      logic pop, acc, push;
      chk(evt_method_err == x_merr, "R3 method_err", 64'(evt_method_err), 64'(x_merr));
      chk(evt_range_err == x_rerr, "R4 range_err", 64'(evt_range_err), 64'(x_rerr));
      chk(src_rst == x_rst, "R5 src_rst", 64'(src_rst), 64'(x_rst));
      chk(nw_ovf == m_ovf, "R9 nw_ovf", 64'(nw_ovf), 64'(m_ovf));
      chk(nw_valid == (q_cnt != 0), "R8 nw_valid", 64'(nw_valid), 64'(q_cnt != 0));
      if (q_cnt != 0 && nw_valid) begin
         chk(nw_addr == q_addr[q_head], "R6 nw_addr", nw_addr, q_addr[q_head]);
         chk(nw_data == q_data[q_head], "R6 nw_data", nw_data, q_data[q_head]);
      end
      evt_vld = ev; evt_idx = IDX_W'(idx); evt_lvl = lvl; nw_ready = rdy;
      cfg_wr = wr; cfg_addr = wa; cfg_wdata = wd;
      pop  = (q_cnt != 0) && rdy;
      acc  = ev && !m_ctrl[63] && (idx < NUM_SRC);
      push = acc && lvl && m_naddr[0];
      x_merr = ev && m_ctrl[63];
      x_rerr = ev && !m_ctrl[63] && (idx >= NUM_SRC);
      x_rst  = wr && (wa == A_CTRL) && wd[62];
      if (acc) m_level[63-idx] = lvl;
      if (pop) begin q_head = (q_head + 1) % 8; q_cnt--; end
      if (push) begin
         if (q_cnt < DEPTH || pop) begin
            q_addr[(q_head + q_cnt) % 8] = {m_naddr[63:1], 1'b0};
            q_data[(q_head + q_cnt) % 8] = exp_payload(m_toff, idx);
            q_cnt++;
         end else m_ovf = 1'b1;
      end
      if (wr) begin
         case (wa)
            A_CTRL:  m_ctrl  = wd;
            A_EBASE: m_ebase = wd;
            A_NADDR: m_naddr = wd;
            A_TOFF:  m_toff  = wd;
            default: ;
         endcase
      end
      @(posedge clk); @(negedge clk);
      evt_vld = 1'b0; cfg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [63:0] exp, input string tag);
      cfg_addr = a; #1;
      chk(cfg_rdata == exp, tag, cfg_rdata, exp);
   endtask

   task automatic idle(input int n, input logic rdy);
      for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, rdy, 1'b0, 8'h0, '0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      rd(A_CTRL, '0, "R1 ctrl");   rd(A_NADDR, '0, "R1 naddr");
      rd(A_TOFF, '0, "R1 toff");   rd(A_LEVEL, '0, "R1 level");
      rd(A_EBASE, '0, "R1 ebase");
      chk(!nw_valid && !nw_ovf && !src_rst, "R1 outputs", {nw_valid, nw_ovf, src_rst}, '0);
      // R10 base readback, level write ignored, unknown offset
      step(1'b0, 0, 0, 1, 1'b1, A_EBASE, 64'hDEAD_BEEF_0123_4560);
      rd(A_EBASE, 64'hDEAD_BEEF_0123_4560, "R10 ebase readback");
      step(1'b0, 0, 0, 1, 1'b1, A_LEVEL, '1);
      rd(A_LEVEL, '0, "R10 level write ignored");
      rd(8'h00, '1, "R10 unknown offset");
      rd(8'h5C, '1, "R10 unaligned offset");
      // R6 basic write
      step(1'b0, 0, 0, 1, 1'b1, A_NADDR, 64'h0000_0040_0000_1001);
      step(1'b0, 0, 0, 1, 1'b1, A_TOFF, 64'h0000_0005_ABCD_EF01);
      step(1'b1, 0, 1, 1, 1'b0, 8'h0, '0);
      rd(A_LEVEL, 64'h8000_0000_0000_0000, "R2 source 0 is bit 63");
      step(1'b1, 13, 1, 1, 1'b0, 8'h0, '0);
      rd(A_LEVEL, 64'h8004_0000_0000_0000, "R2 source 13 is bit 50");
      idle(2, 1);
      // R6 32-bit wrap of interrupt number
      step(1'b0, 0, 0, 1, 1'b1, A_TOFF, 64'hFFFF_FFFF_0000_0000);
      step(1'b1, 3, 1, 1, 1'b0, 8'h0, '0);
      idle(2, 1);
      // R2 clear
      step(1'b1, 0, 0, 1, 1'b0, 8'h0, '0);
      rd(A_LEVEL, 64'h1004_0000_0000_0000, "R2 clear source 0");
      // R7 address invalid
      step(1'b0, 0, 0, 1, 1'b1, A_NADDR, 64'h0000_0040_0000_2000);
      step(1'b1, 5, 1, 1, 1'b0, 8'h0, '0);
      rd(A_LEVEL, 64'h1404_0000_0000_0000, "R7 level still updated");
      idle(2, 1);
      // R4 out of range
      step(1'b0, 0, 0, 1, 1'b1, A_NADDR, 64'h0000_0040_0000_2001);
      step(1'b1, 14, 1, 1, 1'b0, 8'h0, '0);
      step(1'b1, 31, 1, 1, 1'b0, 8'h0, '0);
      rd(A_LEVEL, 64'h1404_0000_0000_0000, "R4 level unchanged");
      idle(2, 1);
      // R3 method bit
      step(1'b0, 0, 0, 1, 1'b1, A_CTRL, 64'h8000_0000_0000_0000);
      step(1'b1, 7, 1, 1, 1'b0, 8'h0, '0);
      step(1'b1, 20, 1, 1, 1'b0, 8'h0, '0);
      rd(A_LEVEL, 64'h1404_0000_0000_0000, "R3 level unchanged");
      // R5 reset pulse, value stored
      step(1'b0, 0, 0, 1, 1'b1, A_CTRL, 64'h4000_0000_0000_00A5);
      rd(A_CTRL, 64'h4000_0000_0000_00A5, "R5 ctrl stored");
      idle(2, 1);
      // R8/R9 queue fill, hold, overflow, drain
      step(1'b0, 0, 0, 0, 1'b1, A_TOFF, 64'h0000_0100_0000_0000);
      for (int i = 0; i < 5; i++) step(1'b1, i + 1, 1, 0, 1'b0, 8'h0, '0);
      idle(3, 0);
      step(1'b1, 9, 1, 1, 1'b0, 8'h0, '0);
      idle(6, 1);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic ev, lvl, rdy, wr;
         int idx, r;
         logic [7:0] wa;
         logic [63:0] wd;
         ev  = ($urandom % 3) != 0;
         idx = $urandom % 18;
         lvl = ($urandom % 4) != 0;
         rdy = ($urandom % 4) != 0;
         r   = $urandom % 40;
         wr  = (r < 4);
         wa  = (r == 0) ? A_CTRL : (r == 1) ? A_NADDR : (r == 2) ? A_TOFF : A_LEVEL;
         wd  = {$urandom, $urandom};
         if (r == 0) wd[63] = ($urandom % 4) == 0;
         if (r == 1) wd[0]  = ($urandom % 4) != 0;
         step(ev, idx, lvl, rdy, wr, wa, wd);
         rd(A_LEVEL, m_level, "R2 random level");
      end
      idle(8, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule